// File: doc/BRIEF.md
# Prescaled PWM Bank with Output Override

A bank of eight pulse-width generators that sits behind a 16-bit register bus. Each channel owns one register holding a 3-bit power-of-two prescaler, a force-high bit and a 12-bit duty value. The channel runs a free period counter of `CNT_W` bits that advances once every 2^prescaler clocks. Its output is high for the first duty/4096 of each period.

Six digital output pins each have a static value and an override enable, both held in one output register. When the enable for pin k is set, the pin follows channel k instead of its static value. Channels 7 and 8 drive two dedicated bridge PWM lines.

New channel settings are staged in the register and copied into the running channel only when its period counter wraps. A pulse is therefore never cut short or stretched in the middle of a period.

Top module: `pwm_bank`

## Requirements
- R1: Channel n (1..8) has a 16-bit register at byte address 0x10 + 2·(n−1), laid out as prescaler [15:13], force-high [12], duty [11:0]. A write stores all 16 bits, and a read at the same address returns them.
- R2: The output register sits at byte address 0x08, laid out as static values [5:0] for pins 6..1 and override enables [11:6]. It reads back with bits [15:12] as zero. A pin whose override is clear shows its static bit.
- R3: A write to any address other than 0x08 or a channel address changes no register. This includes odd addresses. A read at such an address returns zero.
- R4: With a running prescaler p, a channel's period is 2^CNT_W · 2^p clocks, and its output rises once per period.
- R5: The output is high for D · 2^p clocks at the start of each period, where D is duty[11 -: CNT_W] (the whole 12-bit duty when CNT_W is 12).
- R6: When the running force-high bit is set, the channel output stays high whatever the duty holds.
- R7: A duty of zero with force-high clear gives a constant low output.
- R8: A new prescaler, duty or force value takes effect only at the channel's next period wrap. The period already in progress finishes with the old values.
- R9: When override enable k is set, output pin k follows PWM channel k. The other pins keep their static bits.
- R10: Channels 7 and 8 drive bridge lines 0 and 1 respectively, independently of the output register.
- R11: After reset every register reads zero, and all pin and bridge outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| dout | output | 6 | Digital output pins 6..1 |
| hbridge_pwm | output | 2 | PWM lines of channels 8 and 7 |

## Verification
A corrupted period or prescaler counter shows as a wrong count of high clocks or rising edges within one or two periods on the affected pin. The bench therefore measures every channel over windows of exactly two periods, at several prescalers and duties. A shadow register that loads at the wrong moment shows within the period that is running when a new value is written. A mixing fault in the output stage shows at once on the static pins.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    localparam int DATA_W    = 16;
    localparam int PRE_W     = 3;
    localparam int DUTY_FULL = 12;

    // One channel register as it sits on the bus: prescaler, force-high, duty
    typedef struct packed {
        logic [PRE_W-1:0]     pre;
        logic                 force_hi;
        logic [DUTY_FULL-1:0] duty;
    } chan_cfg_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int N_CH     = 8,
    parameter int N_DIRECT = 6,
    parameter int ADDR_W   = 8,
    parameter int OUT_ADDR = 8,
    parameter int PWM_BASE = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic [N_CH-1:0][DATA_W-1:0]   cfg_o,
    output logic [N_DIRECT-1:0]           static_o,
    output logic [N_DIRECT-1:0]           ovr_o
);
    localparam int OUT_W = 2 * N_DIRECT;

    typedef struct packed {
        logic [N_CH-1:0][DATA_W-1:0] cfg;
        logic [OUT_W-1:0]            outr;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (int'(wr_addr) == OUT_ADDR) begin
                st_d.outr = wr_data[OUT_W-1:0];
            end
            for (int i = 0; i < N_CH; i++) begin
                if (int'(wr_addr) == PWM_BASE + 2 * i) begin
                    st_d.cfg[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) == OUT_ADDR) begin
            rd_data = DATA_W'(st_q.outr);
        end
        for (int i = 0; i < N_CH; i++) begin
            if (int'(rd_addr) == PWM_BASE + 2 * i) begin
                rd_data = st_q.cfg[i];
            end
        end
    end

    assign cfg_o    = st_q.cfg;
    assign static_o = st_q.outr[N_DIRECT-1:0];
    assign ovr_o    = st_q.outr[OUT_W-1:N_DIRECT];

    // R2: reserved upper bits of the output register never read back as one
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_addr) == OUT_ADDR) |-> (rd_data[DATA_W-1:OUT_W] == '0));

    // R3: a write to an odd byte address leaves every register untouched
    p_odd_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[0]) |=> $stable(st_q));
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg_i,
    output logic      pwm_o
);
    localparam int PC_W = (1 << PRE_W) - 1;

    typedef struct packed {
        logic [PC_W-1:0]  pre_cnt;
        logic [CNT_W-1:0] per;
        logic [PRE_W-1:0] pre_sh;
        logic [CNT_W-1:0] duty_sh;
        logic             force_sh;
    } chan_t;

    chan_t st_d, st_q;
    logic [PC_W-1:0] mask;
    logic tick, wrap;

    always_comb begin
        for (int b = 0; b < PC_W; b++) begin
            mask[b] = (b < int'(st_q.pre_sh));
        end
        tick = (st_q.pre_cnt == mask);
        wrap = tick && (&st_q.per);

        st_d = st_q;
        if (tick) begin
            st_d.pre_cnt = '0;
            st_d.per     = st_q.per + 1'b1;
        end else begin
            st_d.pre_cnt = st_q.pre_cnt + 1'b1;
        end
        if (wrap) begin
            st_d.pre_sh   = cfg_i.pre;
            st_d.duty_sh  = cfg_i.duty[DUTY_FULL-1 -: CNT_W];
            st_d.force_sh = cfg_i.force_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = st_q.force_sh | (st_q.per < st_q.duty_sh);

    // R6: running force bit pins the output high
    p_force_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.force_sh |-> pwm_o);

    // R7: zero duty without force keeps the output low
    p_zero_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.force_sh && st_q.duty_sh == '0) |-> !pwm_o);

    // R8: running settings only move at a period wrap
    p_hold_midperiod_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(st_q.duty_sh) && $stable(st_q.force_sh) && $stable(st_q.pre_sh)));

    // R4: a nonzero prescaler never gives two counter steps back to back
    p_prescale_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap && st_q.pre_sh != '0) |=> !tick);
endmodule

// File: rtl/pwm_bank_outmux.sv
module pwm_bank_outmux #(
    parameter int N_CH     = 8,
    parameter int N_DIRECT = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_DIRECT-1:0]      static_i,
    input  logic [N_DIRECT-1:0]      ovr_i,
    input  logic [N_CH-1:0]          pwm_i,
    output logic [N_DIRECT-1:0]      dout_o,
    output logic [N_CH-N_DIRECT-1:0] hb_o
);
    genvar k;
    generate
        for (k = 0; k < N_DIRECT; k++) begin : g_pin
            assign dout_o[k] = ovr_i[k] ? pwm_i[k] : static_i[k];

            // R2: no override, static bit on the pin
            p_static_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
                !ovr_i[k] |-> (dout_o[k] == static_i[k]));

            // R9: override set, channel k on pin k
            p_override_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
                ovr_i[k] |-> (dout_o[k] == pwm_i[k]));
        end
    endgenerate

    assign hb_o = pwm_i[N_CH-1:N_DIRECT];

    // R10: bridge lines follow the top channels
    p_bridge_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hb_o == pwm_i[N_CH-1:N_DIRECT]);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int N_CH     = 8,
    parameter int N_DIRECT = 6,
    parameter int CNT_W    = 12,
    parameter int ADDR_W   = 8,
    parameter int OUT_ADDR = 8,
    parameter int PWM_BASE = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic [N_DIRECT-1:0]      dout,
    output logic [N_CH-N_DIRECT-1:0] hbridge_pwm
);
    logic [N_CH-1:0][DATA_W-1:0] cfg;
    logic [N_DIRECT-1:0]         static_v;
    logic [N_DIRECT-1:0]         ovr;
    logic [N_CH-1:0]             pwm;

    pwm_bank_regs #(
        .N_CH(N_CH), .N_DIRECT(N_DIRECT), .ADDR_W(ADDR_W),
        .OUT_ADDR(OUT_ADDR), .PWM_BASE(PWM_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg_o(cfg), .static_o(static_v), .ovr_o(ovr)
    );

    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_chan
            pwm_bank_chan #(.CNT_W(CNT_W)) u_chan (
                .clk(clk), .rst_n(rst_n),
                .cfg_i(chan_cfg_t'(cfg[c])),
                .pwm_o(pwm[c])
            );
        end
    endgenerate

    pwm_bank_outmux #(.N_CH(N_CH), .N_DIRECT(N_DIRECT)) u_mux (
        .clk(clk), .rst_n(rst_n),
        .static_i(static_v), .ovr_i(ovr), .pwm_i(pwm),
        .dout_o(dout), .hb_o(hbridge_pwm)
    );
endmodule

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
    localparam int CNT_W = 4;
    localparam int P0    = 1 << CNT_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [5:0]  dout;
    logic [1:0]  hbridge_pwm;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;
    int old_pre [8];

    always #2 clk = ~clk;

    pwm_bank #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dout(dout), .hbridge_pwm(hbridge_pwm)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[7:0]; wr_data = d[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        @(negedge clk);
        rd_addr = a[7:0];
        #1;
        chk(req, int'(rd_data), exp);
    endtask

    function automatic logic obs(input int ch);
        if (ch <= 6) return dout[ch-1];
        return hbridge_pwm[ch-7];
    endfunction

    task automatic measure(input int ch, input int w, output int hi, output int rises);
        logic prev, cur;
        @(negedge clk);
        prev = obs(ch);
        hi = 0; rises = 0;
        repeat (w) begin
            @(negedge clk);
            cur = obs(ch);
            if (cur) hi++;
            if (cur && !prev) rises++;
            prev = cur;
        end
    endtask

    function automatic int pat(input int i);
        return (16'hA5C3 ^ (i * 16'h1357)) & 16'hFFFF;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int hi, rises, d, reg_v, w, exp_hi, exp_r;
        bit frc;
        string tag;
        for (int i = 0; i < 8; i++) old_pre[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        rd_chk("R11", 8, 0);
        for (int i = 0; i < 8; i++) rd_chk("R11", 16 + 2 * i, 0);
        chk("R11 dout", int'(dout), 0);
        chk("R11 bridge", int'(hbridge_pwm), 0);

        // R1: full 16-bit readback of every channel register
        for (int i = 0; i < 8; i++) wr(16 + 2 * i, pat(i));
        for (int i = 0; i < 8; i++) rd_chk("R1", 16 + 2 * i, pat(i));

        // R2: reserved bits of the output register read as zero
        wr(8, 16'hFFFF);
        rd_chk("R2 reserved", 8, 16'h0FFF);
        wr(8, 16'h002A);
        @(negedge clk);
        chk("R2 static pins", int'(dout), 6'h2A);

        // R3: unmapped and odd writes change nothing and read zero
        wr(8'h0A, 16'hFFFF);
        wr(8'h11, 16'hFFFF);
        wr(8'h20, 16'hFFFF);
        wr(8'h09, 16'hFFFF);
        rd_chk("R3 outreg kept", 8, 16'h002A);
        for (int i = 0; i < 8; i++) rd_chk("R3 chan kept", 16 + 2 * i, pat(i));
        rd_chk("R3 unmapped read", 8'h0A, 0);
        rd_chk("R3 odd read", 8'h11, 0);
        chk("R3 pins kept", int'(dout), 6'h2A);

        // Park all channels at zero and let the longest old period drain
        for (int i = 0; i < 8; i++) wr(16 + 2 * i, 0);
        repeat (2 * (P0 << 7) + 8) @(negedge clk);
        wr(8, 16'h0FC0);

        // R4..R7, R10: sweep channels, prescalers, duties and force
        for (int ch = 1; ch <= 8; ch++) begin
            for (int pre = 0; pre <= 2; pre++) begin
                for (int m = 0; m < 5; m++) begin
                    frc = (m == 4);
                    case (m)
                        0: d = 0;
                        1: d = 1;
                        2: d = 7;
                        3: d = P0 - 1;
                        default: d = 0;
                    endcase
                    reg_v = (pre << 13) | (frc ? (16'h1000 | 16'h00A5) : (d << (12 - CNT_W)));
                    wr(16 + 2 * (ch - 1), reg_v);
                    repeat ((P0 << old_pre[ch-1]) + (P0 << pre) + 2) @(negedge clk);
                    old_pre[ch-1] = pre;
                    w = 2 * (P0 << pre);
                    measure(ch, w, hi, rises);
                    exp_hi = frc ? w : (2 * (d << pre));
                    exp_r  = (frc || d == 0) ? 0 : 2;
                    if (frc)         tag = "R6 force";
                    else if (d == 0) tag = "R7 zero";
                    else             tag = "R5 high time";
                    if (ch > 6) tag = {tag, " R10 bridge"};
                    chk($sformatf("%s ch%0d pre%0d d%0d", tag, ch, pre, d), hi, exp_hi);
                    chk($sformatf("R4 rises ch%0d pre%0d d%0d", ch, pre, d), rises, exp_r);
                end
            end
        end

        // R8: a duty change mid-period leaves the running period intact
        wr(16, 16'h0800);
        repeat ((P0 << old_pre[0]) + P0 + 2) @(negedge clk);
        old_pre[0] = 0;
        begin
            logic prev;
            int guard = 0;
            prev = dout[0];
            @(negedge clk);
            while (!(dout[0] && !prev) && guard < 100) begin
                prev = dout[0];
                @(negedge clk);
                guard++;
            end
        end
        wr(16, 16'h0000);
        chk("R8 still high after write", int'(dout[0]), 1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R8 old duty kept", int'(dout[0]), 1);
        end
        repeat (P0) @(negedge clk);
        measure(1, P0, hi, rises);
        chk("R8 new duty after wrap", hi, 0);

        // R9: override on pins 1 and 2 only, statics elsewhere
        wr(16, 16'h1000);
        wr(18, 16'h0000);
        repeat (3 * (P0 << 2) + 4) @(negedge clk);
        wr(8, (6'b000011 << 6) | 6'b010111);
        @(negedge clk);
        chk("R9 mixed pins", int'(dout), 6'b010101);
        rd_chk("R9 outreg readback", 8, 16'h00D7);

        finish_run();
    end
endmodule